// File: doc/BRIEF.md
# PCI Interrupt Summary Controller

This block collects nineteen level-sensitive interrupt requests: four per PCI option slot (lines A to D on each of four slots) plus the legacy bus bridge, the IDE controller and the USB controller. A host reaches them through three consecutive byte-wide I/O locations on a simple register bus. A read of one of these locations returns one byte of the live request state, taken after a synchronizer. A write to the same location loads one byte of the per-source mask. A mask bit of 1 blocks its source. The mask cannot be read back, so software keeps its own shadow copy when it needs a read-modify-write.

The block drives one interrupt line to the processor. That line is high while any source is both active and unmasked. Summary bit n stands for system interrupt 16+n. The byte at offset k from the base address therefore carries interrupts 16+8k to 16+8k+7.

Top module: `pci_irq_summary`

## Requirements
- R1: After reset every mask bit is 1. `cpu_irq` stays low whatever the request inputs do until software clears a mask bit.
- R2: Only the addresses BASE (0x804), BASE+1 and BASE+2 are decoded. A write to any other address leaves the masks unchanged. A read from any other address returns 0.
- R3: Writing 1 to a mask bit blocks the matching source. Writing 0 unblocks it. Each of the 19 sources has its own mask bit.
- R4: A read returns the synchronized request state, independent of the mask.
- R5: Byte BASE: bits 3..0 = line A of slots 3..0, bit 4 = bridge, bit 5 = IDE, bit 6 = USB, bit 7 = line B of slot 0. The same positions apply to the mask.
- R6: Byte BASE+1: bits 2..0 = line B of slots 3..1, bits 6..3 = line C of slots 3..0, bit 7 = line D of slot 0. The same positions apply to the mask.
- R7: Byte BASE+2: bits 2..0 = line D of slots 3..1. Bits 7..3 read as 0 and are not stored on a write.
- R8: `cpu_irq` is registered. It equals the OR over all sources of (request AND NOT mask), taken one clock earlier. A mask write latched on edge E shows on `cpu_irq` after edge E+1.
- R9: A request passes through two flops. A change applied before edge P shows in read data after edge P+1, and on `cpu_irq` after edge P+2.
- R10: `io_rdata` is 0 whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 12 | I/O byte address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data (mask byte) |
| io_rdata | output | 8 | Read data (raw request byte), combinational |
| slot_inta | input | 4 | Line A of slots 3..0 |
| slot_intb | input | 4 | Line B of slots 3..0 |
| slot_intc | input | 4 | Line C of slots 3..0 |
| slot_intd | input | 4 | Line D of slots 3..0 |
| bridge_req | input | 1 | Legacy bus bridge request |
| ide_req | input | 1 | IDE controller request |
| usb_req | input | 1 | USB controller request |
| cpu_irq | output | 1 | Combined interrupt to the processor |

## Verification
Read data is combinational in the cycle the strobe is held. A request edge reaches read data two clock edges after it is applied, and reaches `cpu_irq` three edges after it is applied. A mask write reaches `cpu_irq` on the edge after the one that stores it. The bench drives every input one time unit after a rising edge and samples on the falling edge. The scoreboard monitor compares a queued read result in the falling-edge half of the strobe cycle. Interrupt checks are placed on the cycle just before and just after the expected change, so a latency that is one cycle off fails.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam int NSLOT = 4;
  localparam int NSRC  = 4 * NSLOT + 3;
  localparam int NBYTE = (NSRC + 7) / 8;
  localparam int PADW  = NBYTE * 8;
  // Bit positions in the summary vector; the host decodes these.
  localparam int IDX_INTA   = 0;
  localparam int IDX_BRIDGE = NSLOT;
  localparam int IDX_IDE    = NSLOT + 1;
  localparam int IDX_USB    = NSLOT + 2;
  localparam int IDX_INTB   = NSLOT + 3;
  localparam int IDX_INTC   = 2 * NSLOT + 3;
  localparam int IDX_INTD   = 3 * NSLOT + 3;
endpackage

// File: rtl/pis_sync.sv
module pis_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pis_decode.sv
module pis_decode #(
  parameter int                 ADDR_W = 12,
  parameter logic [ADDR_W-1:0]  BASE   = 12'h804,
  parameter int                 NBYTE  = 3
) (
  input  logic [ADDR_W-1:0] io_addr,
  output logic [NBYTE-1:0]  sel
);
  generate
    for (genvar k = 0; k < NBYTE; k++) begin : g_sel
      assign sel[k] = (io_addr == ADDR_W'(BASE + k));
    end
  endgenerate
endmodule

// File: rtl/pis_mask.sv
module pis_mask
  import pis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [NBYTE-1:0] sel,
  input  logic [7:0]       io_wdata,
  output logic [NSRC-1:0]  mask_q
);
  logic [NSRC-1:0] mask_d;
  logic            wr_en;

  assign wr_en = io_wr && (|sel);

  // Only implemented bits exist; reserved write bits have no flop.
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
      assign mask_d[i] = sel[i / 8] ? io_wdata[i % 8] : mask_q[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '1;
    else if (wr_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/pis_summary.sv
module pis_summary
  import pis_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] mask,
  output logic            cpu_irq
);
  logic irq_d;

  always_comb begin
    irq_d = |(status & ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= irq_d;
  end
endmodule

// File: rtl/pci_irq_summary.sv
module pci_irq_summary
  import pis_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] BASE        = 12'h804,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [NSLOT-1:0]  slot_inta,
  input  logic [NSLOT-1:0]  slot_intb,
  input  logic [NSLOT-1:0]  slot_intc,
  input  logic [NSLOT-1:0]  slot_intd,
  input  logic              bridge_req,
  input  logic              ide_req,
  input  logic              usb_req,
  output logic              cpu_irq
);
  logic [NSRC-1:0]  req_raw;
  logic [NSRC-1:0]  status_s;
  logic [NSRC-1:0]  mask_q;
  logic [NBYTE-1:0] sel;
  logic [PADW-1:0]  stat_pad;

  always_comb begin
    req_raw = '0;
    req_raw[IDX_INTA +: NSLOT] = slot_inta;
    req_raw[IDX_BRIDGE]        = bridge_req;
    req_raw[IDX_IDE]           = ide_req;
    req_raw[IDX_USB]           = usb_req;
    req_raw[IDX_INTB +: NSLOT] = slot_intb;
    req_raw[IDX_INTC +: NSLOT] = slot_intc;
    req_raw[IDX_INTD +: NSLOT] = slot_intd;
  end

  pis_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_raw), .q(status_s)
  );

  pis_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NBYTE(NBYTE)) u_dec (
    .io_addr(io_addr), .sel(sel)
  );

  pis_mask u_mask (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .sel(sel),
    .io_wdata(io_wdata), .mask_q(mask_q)
  );

  pis_summary u_sum (
    .clk(clk), .rst_n(rst_n), .status(status_s), .mask(mask_q),
    .cpu_irq(cpu_irq)
  );

  assign stat_pad = {{(PADW-NSRC){1'b0}}, status_s};

  always_comb begin
    io_rdata = '0;
    for (int k = 0; k < NBYTE; k++) begin
      if (io_rd && sel[k]) io_rdata = stat_pad[k*8 +: 8];
    end
  end
endmodule

// File: rtl/pis_checker.sv
module pis_checker
  import pis_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE   = 12'h804
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cpu_irq,
  input logic [NSRC-1:0]   status,
  input logic [NSRC-1:0]   mask
);
  logic in_range;
  assign in_range = (io_addr == BASE) || (io_addr == ADDR_W'(BASE + 1)) ||
                    (io_addr == ADDR_W'(BASE + 2));

  p_mask_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == BASE) |=> (mask[7:0] == $past(io_wdata)));

  p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&mask) |-> !cpu_irq);

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == $past(|(status & ~mask)));

  p_raw_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == BASE) |-> (io_rdata == status[7:0]));

  p_rsv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ADDR_W'(BASE + 2)) |-> (io_rdata[7:3] == 5'd0));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'd0));

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !in_range) |-> (io_rdata == 8'd0));

  p_miss_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !in_range) |=> $stable(mask));
endmodule

bind pci_irq_summary pis_checker #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_irq(cpu_irq),
  .status(status_s), .mask(mask_q)
);

// File: tb/pci_irq_summary_bench.sv
`timescale 1ns/1ps
module pci_irq_summary_bench;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata, io_rdata;
  logic        cpu_irq;
  logic [18:0] src;
  logic        sb_en;
  int          nchk = 0;
  int          nfail = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #2.5 clk = ~clk;

  pci_irq_summary u_pci_irq_summary (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .slot_inta(src[3:0]), .slot_intb(src[10:7]), .slot_intc(src[14:11]),
    .slot_intd(src[18:15]), .bridge_req(src[4]), .ide_req(src[5]),
    .usb_req(src[6]), .cpu_irq(cpu_irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k);
    logic [23:0] pad;
    pad = {5'd0, src};
    return pad[k*8 +: 8];
  endfunction

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    sb_q.push_back(it);
    io_addr = a; io_rd = 1'b1; sb_en = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0; sb_en = 1'b0;
  endtask

  // Scoreboard monitor: combinational read data, sampled mid-cycle.
  always @(negedge clk) begin
    if (sb_en) begin
      if (sb_q.size() == 0) begin
        chk(32'd1, 32'd0, "scoreboard underflow");
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        chk({24'd0, io_rdata}, {24'd0, it.exp}, it.tag);
      end
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; io_addr = 12'h000; io_rd = 1'b0; io_wr = 1'b0;
    io_wdata = 8'h00; src = '0; sb_en = 1'b0;
    settle(4);
    rst_n = 1'b1;
    settle(1);

    // R1 / R10: reset state
    chk({31'd0, cpu_irq}, 32'd0, "R1 irq after reset");
    chk({24'd0, io_rdata}, 32'd0, "R10 rdata idle after reset");
    src = '1;
    settle(4);
    chk({31'd0, cpu_irq}, 32'd0, "R1 all masked, all active");
    // R10: no read strobe
    io_addr = 12'h804;
    #1;
    chk({24'd0, io_rdata}, 32'd0, "R10 rdata without strobe");
    do_read(12'h804, 8'hFF, "R4 raw byte0 under full mask");
    do_read(12'h805, 8'hFF, "R4 raw byte1 under full mask");
    do_read(12'h806, 8'h07, "R7 raw byte2 reserved zero");

    // R5/R6/R7: walking one through the layout
    for (int i = 0; i < 19; i++) begin
      src = 19'd1 << i;
      settle(2);
      do_read(12'h804 + 12'(i / 8), exp_byte(i / 8),
              (i < 8) ? "R5 layout walk" : (i < 16) ? "R6 layout walk" : "R7 layout walk");
    end

    // R3 / R8: unmask one line (line C slot 0 = bit 11 = byte1 bit3)
    src = 19'd1 << 11;
    settle(3);
    do_write(12'h805, 8'hF7);
    chk({31'd0, cpu_irq}, 32'd0, "R8 irq not yet after mask write");
    settle(1);
    chk({31'd0, cpu_irq}, 32'd1, "R3 unmasked source raises irq");
    src = 19'd1 << 12;
    settle(3);
    chk({31'd0, cpu_irq}, 32'd0, "R3 neighbour still masked");
    src = 19'd1 << 11;
    settle(3);
    do_write(12'h805, 8'hFF);
    settle(1);
    chk({31'd0, cpu_irq}, 32'd0, "R3 remask drops irq");

    // R2: out-of-range writes and reads
    src = '1;
    settle(3);
    do_write(12'h803, 8'h00);
    do_write(12'h807, 8'h00);
    do_write(12'h004, 8'h00);
    settle(2);
    chk({31'd0, cpu_irq}, 32'd0, "R2 stray writes leave masks set");
    do_read(12'h807, 8'h00, "R2 read above range");
    do_read(12'h803, 8'h00, "R2 read below range");

    // R7: reserved bits in byte2
    do_write(12'h806, 8'hFF);
    do_read(12'h806, 8'h07, "R7 reserved read zero after write ones");
    do_write(12'h806, 8'hF8);
    settle(1);
    chk({31'd0, cpu_irq}, 32'd1, "R7 byte2 low bits unmask line D");
    do_write(12'h806, 8'h07);
    settle(1);
    chk({31'd0, cpu_irq}, 32'd0, "R7 byte2 low bits remask line D");

    // R4: read independent of mask
    do_write(12'h804, 8'h00);
    do_write(12'h805, 8'h00);
    do_write(12'h806, 8'h00);
    src = 19'h5A5A5;
    settle(2);
    do_read(12'h804, exp_byte(0), "R4 raw byte0 unmasked");
    do_read(12'h805, exp_byte(1), "R4 raw byte1 unmasked");
    do_read(12'h806, exp_byte(2), "R4 raw byte2 unmasked");
    chk({31'd0, cpu_irq}, 32'd1, "R8 irq with unmasked pattern");

    // R9: synchronizer latency
    src = '0;
    settle(3);
    chk({31'd0, cpu_irq}, 32'd0, "R8 irq idle before latency test");
    io_addr = 12'h804; io_rd = 1'b1;
    @(posedge clk); #1;
    src = 19'd1;
    @(posedge clk); @(negedge clk);
    chk({24'd0, io_rdata}, 32'd0, "R9 read after one edge");
    @(posedge clk); @(negedge clk);
    chk({24'd0, io_rdata}, 32'd1, "R9 read after two edges");
    chk({31'd0, cpu_irq}, 32'd0, "R9 irq after two edges");
    @(posedge clk); @(negedge clk);
    chk({31'd0, cpu_irq}, 32'd1, "R9 irq after three edges");
    @(posedge clk); #1;
    io_rd = 1'b0;
    #1;
    chk({24'd0, io_rdata}, 32'd0, "R10 rdata after strobe drops");

    settle(2);
    finish_run();
  end
endmodule